// File: doc/BRIEF.md
# Event Elapsed Time Logger

This block measures how long an external event signal stays asserted and how many times it has been asserted. The raw event level is first cleaned by a glitch filter. While the filtered level is high, an elapsed-time register advances once per quarter-second tick. The tick comes from a prescaler that restarts at the start of each event. When an event starts, the elapsed-time register is reloaded from the running total. The same reload happens on a power-up strobe. When the event ends, the elapsed value is written back into the total and an event tally is advanced.

The total is treated as slow nonvolatile storage. It is written one segment at a time, least significant segment first, with a fixed latency per segment, and a busy flag covers the whole write. After every accepted change of the event level, the register bus that sits next to this core is told it may not be used for a programmable hold window. A clear request zeroes the elapsed time, the total and the tally. If a write-back is in progress, the clear waits until it finishes.

Top module: `event_time_logger`

## Requirements
- R1: While `rst_n` is low and right after it is released, `elapsed_q`, `total_q`, `evt_count_q`, `evt_wrap_q`, `store_busy` and `bus_unavail` are all zero.
- R2: While the filtered event is high, `elapsed_q` grows by one every TICK_DIV cycles, counted from the start of the event. An event whose filtered level is high for H cycles adds floor(H/TICK_DIV).
- R3: On each start of an event, and on a `pwr_up` pulse, `elapsed_q` is loaded from `total_q`. This makes the elapsed time continue across events.
- R4: On each end of an event, the value of `elapsed_q` is written into `total_q` and `evt_count_q` grows by one.
- R5: `elapsed_q` stops at all ones and never wraps to zero.
- R6: The tally works as EVT_W bits plus `evt_wrap_q` acting as the top bit. The first step past all ones gives zero with `evt_wrap_q` set. Once `evt_wrap_q` is set, the tally stays at all ones.
- R7: The glitch filter ignores any change of `event_in` that lasts fewer than FILT_LEN clock samples. This holds both for a spike while idle and for a dip during an event.
- R8: `bus_unavail` goes high within a few cycles of an accepted event change and stays high for BUS_HOLD cycles after it.
- R9: The write into `total_q` is done in segments of SEG_W bits, least significant first, one segment every SEG_LAT cycles. `store_busy` is high for (CNT_W/SEG_W)*SEG_LAT cycles.
- R10: A `clr_req` pulse zeroes `elapsed_q`, `total_q`, `evt_count_q` and `evt_wrap_q`. If it arrives while `store_busy` is high, nothing is cleared until the write has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_in | input | 1 | Raw event level, high while the event is active |
| pwr_up | input | 1 | One-cycle strobe: reload elapsed time from the total |
| clr_req | input | 1 | One-cycle request to clear all counters |
| elapsed_q | output | CNT_W | Elapsed time in quarter-second units |
| total_q | output | CNT_W | Stored total time |
| evt_count_q | output | EVT_W | Event tally, low bits |
| evt_wrap_q | output | 1 | Tally rollover flag (top bit of the tally) |
| store_busy | output | 1 | Write-back of the total in progress |
| bus_unavail | output | 1 | Register bus must not be used |

## Verification
The main function is driven with events of several lengths. Lengths that are whole multiples of the tick period are mixed with lengths that leave a remainder, which separates correct tick phasing from an off-by-one start of the prescaler. Spikes and a short dip shorter than the filter window are mixed in, and they must change neither the time nor the tally. The total is sampled partway through a write-back, with old and new values that differ in both segments, to show the segment order. A power-up strobe during an event, a clear that lands during a write-back, a long run into saturation and a run of events past the tally rollover cover the remaining orderings.

// File: rtl/etl_pkg.sv
package etl_pkg;
  typedef enum logic [0:0] {
    CM_IDLE  = 1'b0,
    CM_WRITE = 1'b1
  } commit_state_e;
endpackage

// File: rtl/etl_glitch_filter.sv
module etl_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic          sync1_q, sync2_q;
  logic          lvl_q, lvl_d;
  logic [CW-1:0] run_q, run_d;

  always_comb begin
    lvl_d = lvl_q;
    run_d = '0;
    if (sync2_q != lvl_q) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        lvl_d = sync2_q;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      lvl_q   <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      lvl_q   <= lvl_d;
      run_q   <= run_d;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/etl_quarter_tick.sv
module etl_quarter_tick #(
  parameter int TICK_DIV = 31_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic          wrap;

  assign wrap = (pre_q == PW'(TICK_DIV - 1));

  always_comb begin
    if (!run_i || wrap) pre_d = '0;
    else                pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = run_i & wrap;
endmodule

// File: rtl/etl_hold_timer.sv
module etl_hold_timer #(
  parameter int HOLD = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] left_q, left_d;

  always_comb begin
    if (trig_i)              left_d = HW'(HOLD);
    else if (left_q != '0)   left_d = left_q - 1'b1;
    else                     left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign active_o = (left_q != '0);
endmodule

// File: rtl/etl_commit.sv
module etl_commit
  import etl_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SEG_W   = 8,
  parameter int SEG_LAT = 4_687_500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] acc_o,
  output logic             busy_o
);
  localparam int NSEG = CNT_W / SEG_W;
  localparam int IW   = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int LW   = (SEG_LAT > 1) ? $clog2(SEG_LAT) : 1;

  commit_state_e    st_q, st_d;
  logic [CNT_W-1:0] snap_q, snap_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [LW-1:0]    lat_q, lat_d;
  logic             fire;
  logic [NSEG-1:0]  seg_we;

  assign fire = (st_q == CM_WRITE) && (lat_q == LW'(SEG_LAT - 1));

  always_comb begin
    st_d   = st_q;
    snap_d = snap_q;
    idx_d  = idx_q;
    lat_d  = lat_q;
    if (start_i) begin
      st_d   = CM_WRITE;
      snap_d = data_i;
      idx_d  = '0;
      lat_d  = '0;
    end else if (st_q == CM_WRITE) begin
      if (fire) begin
        lat_d = '0;
        idx_d = idx_q + 1'b1;
        if (idx_q == IW'(NSEG - 1)) st_d = CM_IDLE;
      end else begin
        lat_d = lat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CM_IDLE;
      snap_q <= '0;
      idx_q  <= '0;
      lat_q  <= '0;
    end else begin
      st_q   <= st_d;
      snap_q <= snap_d;
      idx_q  <= idx_d;
      lat_q  <= lat_d;
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign seg_we[g] = fire && (idx_q == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_o[g*SEG_W +: SEG_W] <= '0;
      else if (clr_i)     acc_o[g*SEG_W +: SEG_W] <= '0;
      else if (seg_we[g]) acc_o[g*SEG_W +: SEG_W] <= snap_q[g*SEG_W +: SEG_W];
    end
  end

  assign busy_o = (st_q == CM_WRITE);
endmodule

// File: rtl/event_time_logger.sv
module event_time_logger #(
  parameter int CNT_W    = 32,
  parameter int SEG_W    = 8,
  parameter int EVT_W    = 16,
  parameter int FILT_LEN = 4,
  parameter int TICK_DIV = 31_250_000,
  parameter int BUS_HOLD = 25_000_000,
  parameter int SEG_LAT  = 4_687_500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_in,
  input  logic             pwr_up,
  input  logic             clr_req,
  output logic [CNT_W-1:0] elapsed_q,
  output logic [CNT_W-1:0] total_q,
  output logic [EVT_W-1:0] evt_count_q,
  output logic             evt_wrap_q,
  output logic             store_busy,
  output logic             bus_unavail
);
  localparam logic [CNT_W-1:0] TIME_MAX = {CNT_W{1'b1}};
  localparam logic [EVT_W-1:0] EVT_MAX  = {EVT_W{1'b1}};

  logic [1:0]       rst_pipe_q;
  logic             rst_ni;
  logic             ev_lvl, ev_d_q;
  logic             rise, fall, tick;
  logic             load_now, clr_pend_q, clr_apply;
  logic [CNT_W-1:0] elapsed_d;
  logic [EVT_W-1:0] evt_count_d;
  logic             evt_wrap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  etl_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_ni), .raw_i(event_in), .lvl_o(ev_lvl)
  );

  etl_quarter_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_ni), .run_i(ev_lvl), .tick_o(tick)
  );

  etl_hold_timer #(.HOLD(BUS_HOLD)) u_bus_hold (
    .clk(clk), .rst_n(rst_ni), .trig_i(rise | fall), .active_o(bus_unavail)
  );

  etl_commit #(.CNT_W(CNT_W), .SEG_W(SEG_W), .SEG_LAT(SEG_LAT)) u_commit (
    .clk(clk), .rst_n(rst_ni), .start_i(fall), .data_i(elapsed_q),
    .clr_i(clr_apply), .acc_o(total_q), .busy_o(store_busy)
  );

  assign rise      = ev_lvl & ~ev_d_q;
  assign fall      = ~ev_lvl & ev_d_q;
  assign load_now  = (pwr_up | rise) & ~store_busy;
  assign clr_apply = clr_pend_q & ~store_busy & ~fall;

  always_comb begin
    elapsed_d = elapsed_q;
    if (clr_apply)                        elapsed_d = '0;
    else if (load_now)                    elapsed_d = total_q;
    else if (tick && elapsed_q != TIME_MAX) elapsed_d = elapsed_q + 1'b1;
  end

  always_comb begin
    evt_count_d = evt_count_q;
    evt_wrap_d  = evt_wrap_q;
    if (clr_apply) begin
      evt_count_d = '0;
      evt_wrap_d  = 1'b0;
    end else if (fall) begin
      if (evt_count_q != EVT_MAX) begin
        evt_count_d = evt_count_q + 1'b1;
      end else if (!evt_wrap_q) begin
        evt_count_d = '0;
        evt_wrap_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_d_q      <= 1'b0;
      clr_pend_q  <= 1'b0;
      elapsed_q   <= '0;
      evt_count_q <= '0;
      evt_wrap_q  <= 1'b0;
    end else begin
      ev_d_q      <= ev_lvl;
      clr_pend_q  <= (clr_pend_q | clr_req) & ~clr_apply;
      elapsed_q   <= elapsed_d;
      evt_count_q <= evt_count_d;
      evt_wrap_q  <= evt_wrap_d;
    end
  end
endmodule

// File: rtl/etl_checker.sv
module etl_checker #(
  parameter int CNT_W = 32,
  parameter int EVT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_lvl,
  input logic             load_now,
  input logic             clr_apply,
  input logic [CNT_W-1:0] elapsed_q,
  input logic [EVT_W-1:0] evt_count_q,
  input logic             evt_wrap_q,
  input logic             store_busy,
  input logic             bus_unavail
);
  localparam logic [CNT_W-1:0] TIME_MAX = {CNT_W{1'b1}};
  localparam logic [EVT_W-1:0] EVT_MAX  = {EVT_W{1'b1}};

  AST_TIME_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_lvl && !load_now && !clr_apply) |=> $stable(elapsed_q)); // R2

  AST_TIME_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_now && !clr_apply) |=>
      (elapsed_q == $past(elapsed_q) || elapsed_q == $past(elapsed_q) + 1'b1)); // R2

  AST_TIME_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed_q == TIME_MAX && !load_now && !clr_apply) |=> elapsed_q == TIME_MAX); // R5

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wrap_q && !clr_apply) |=> evt_wrap_q); // R6

  AST_CLEAR_WAITS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (store_busy && evt_count_q != '0 && evt_count_q != EVT_MAX) |=> evt_count_q != '0); // R10

  AST_BUS_BLOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ev_lvl) || $fell(ev_lvl)) |=> bus_unavail); // R8
endmodule

bind event_time_logger etl_checker #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_lvl(ev_lvl), .load_now(load_now),
  .clr_apply(clr_apply), .elapsed_q(elapsed_q), .evt_count_q(evt_count_q),
  .evt_wrap_q(evt_wrap_q), .store_busy(store_busy), .bus_unavail(bus_unavail)
);

// File: tb/tb_event_time_logger.sv
module tb_event_time_logger;
  localparam int CNT_W    = 12;
  localparam int SEG_W    = 4;
  localparam int EVT_W    = 4;
  localparam int FILT_LEN = 4;
  localparam int TICK_DIV = 4;
  localparam int BUS_HOLD = 24;
  localparam int SEG_LAT  = 3;
  localparam int NSEG     = CNT_W / SEG_W;

  typedef struct packed {
    int hi;
    int exp_time;
    int exp_cnt;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8, 2, 1}, '{11, 4, 2}, '{3, 4, 2}, '{16, 8, 3},
    '{2, 8, 3}, '{40, 18, 4}, '{5, 19, 5}
  };

  logic             clk = 1'b0;
  logic             rst_n, event_in, pwr_up, clr_req;
  logic [CNT_W-1:0] elapsed_q, total_q;
  logic [EVT_W-1:0] evt_count_q;
  logic             evt_wrap_q, store_busy, bus_unavail;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  event_time_logger #(
    .CNT_W(CNT_W), .SEG_W(SEG_W), .EVT_W(EVT_W), .FILT_LEN(FILT_LEN),
    .TICK_DIV(TICK_DIV), .BUS_HOLD(BUS_HOLD), .SEG_LAT(SEG_LAT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .event_in(event_in), .pwr_up(pwr_up),
    .clr_req(clr_req), .elapsed_q(elapsed_q), .total_q(total_q),
    .evt_count_q(evt_count_q), .evt_wrap_q(evt_wrap_q),
    .store_busy(store_busy), .bus_unavail(bus_unavail)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_event(input int hi, input int lo);
    @(negedge clk) event_in = 1'b1;
    repeat (hi) @(negedge clk);
    event_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk) clr_req = 1'b1;
    @(negedge clk) clr_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; event_in = 1'b0; pwr_up = 1'b0; clr_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 elapsed in reset", elapsed_q, 0);
    chk("R1 total in reset", total_q, 0);
    chk("R1 count in reset", {evt_wrap_q, evt_count_q}, 0);
    chk("R1 flags in reset", {store_busy, bus_unavail}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {elapsed_q, total_q, evt_count_q, evt_wrap_q, store_busy, bus_unavail}, 0);

    // R2 R3 R4 R7 table of event lengths, spikes included
    for (int i = 0; i < NVEC; i++) begin
      run_event(VECS[i].hi, 40);
      chk("R2 elapsed after event", elapsed_q, VECS[i].exp_time);
      chk("R4 total after event", total_q, VECS[i].exp_time);
      chk("R7 R4 tally after event", evt_count_q, VECS[i].exp_cnt);
    end
    chk("R7 spikes left bus free", bus_unavail, 0);

    // R8 bus window and R9 segment order, total 19 -> 36
    @(negedge clk) event_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 bus blocked after rise", bus_unavail, 1);
    repeat (30) @(negedge clk);
    chk("R8 bus free after window", bus_unavail, 0);
    repeat (28) @(negedge clk);
    event_in = 1'b0;
    @(posedge store_busy);
    repeat (SEG_LAT) @(posedge clk);
    #1;
    chk("R9 low segment written first", total_q[SEG_W-1:0], 36 % 16);
    chk("R9 upper segments still old", total_q[CNT_W-1:SEG_W], 19 / 16);
    n = SEG_LAT;
    while (store_busy) begin
      @(posedge clk);
      #1;
      n++;
    end
    chk("R9 busy length", n, NSEG * SEG_LAT);
    chk("R4 total after segmented write", total_q, 36);
    repeat (30) @(negedge clk);

    // R7 short dip inside an event: 42 high cycles -> +10
    @(negedge clk) event_in = 1'b1;
    repeat (20) @(negedge clk);
    event_in = 1'b0;
    repeat (2) @(negedge clk);
    event_in = 1'b1;
    repeat (20) @(negedge clk);
    event_in = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 dip ignored, time", total_q, 46);
    chk("R7 dip ignored, tally", evt_count_q, 7);

    // R3 power-up strobe reloads from the total during an event
    @(negedge clk) event_in = 1'b1;
    repeat (30) @(negedge clk);
    pwr_up = 1'b1;
    @(negedge clk) pwr_up = 1'b0;
    chk("R3 reload on power-up", elapsed_q, 46);
    repeat (50) @(negedge clk);
    event_in = 1'b0;
    repeat (40) @(negedge clk);

    // R10 clear during a write-back is deferred
    @(negedge clk) event_in = 1'b1;
    repeat (20) @(negedge clk);
    event_in = 1'b0;
    @(posedge store_busy);
    @(negedge clk) clr_req = 1'b1;
    @(negedge clk) clr_req = 1'b0;
    chk("R10 still busy", store_busy, 1);
    chk("R10 tally kept during write", evt_count_q, 9);
    chk("R10 time kept during write", elapsed_q != 0, 1);
    wait (store_busy == 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 cleared after write", {elapsed_q, total_q, evt_count_q, evt_wrap_q}, 0);

    // R6 tally rollover then saturation
    for (int e = 1; e <= 33; e++) begin
      run_event(8, 24);
      if (e == 15) chk("R6 before wrap", {evt_wrap_q, evt_count_q}, 15);
      if (e == 16) chk("R6 first wrap", {evt_wrap_q, evt_count_q}, 16);
      if (e == 31) chk("R6 after wrap at max", {evt_wrap_q, evt_count_q}, 31);
      if (e == 33) chk("R6 saturated", {evt_wrap_q, evt_count_q}, 31);
    end

    // R5 elapsed time saturation
    clear_all();
    chk("R10 idle clear", {elapsed_q, total_q, evt_count_q, evt_wrap_q}, 0);
    @(negedge clk) event_in = 1'b1;
    repeat (16400) @(negedge clk);
    chk("R5 elapsed stops at max", elapsed_q, 4095);
    event_in = 1'b0;
    repeat (40) @(negedge clk);
    chk("R5 total holds max", total_q, 4095);
    chk("R4 tally after long event", evt_count_q, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule